// File: doc/BRIEF.md
# Event Status and Mask Interrupt Aggregator

This block gathers ninety-six single-cycle event strobes from peripherals into three 32-bit status words and drives three level-sensitive interrupt lines. Each line has its own group of three mask words, one per status word, so any event can be steered to none, one, two or all three lines independently. Software acknowledges an event by writing a one back to its status bit.

A small 32-bit register bus (byte address, write enable, write data, combinational read data) reaches the status words, the nine mask words and three read-only vector words. Each vector word names the lowest-numbered event that is both pending and enabled for its line, so an interrupt handler can find its source with one read instead of scanning status and mask words itself.

Top module: `evt_irq_aggr`

## Requirements
- R1: After reset every status bit and every mask bit is 0, every interrupt line is low and every vector word reads 0.
- R2: An event input e that is high at a rising clock edge sets bit e mod 32 of status word e/32; status word n is read at byte offset 4*n (0x00, 0x04, 0x08).
- R3: A write to a status word clears exactly the bits written as 1; bits written as 0 keep their value, and no status bit clears without such a write.
- R4: When an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: Mask word k of group g sits at byte offset 0x10*(g+1) + 4*k, is read/write, and changes only when written.
- R6: Interrupt line g (bit g of the interrupt output) is high exactly while some status bit is 1 together with the matching bit of mask group g; it stays high over idle cycles until the event is acknowledged or masked.
- R7: The vector word for line g sits at byte offset 0x40 + 4*g; bit 31 is a valid flag and bits 6:0 give the lowest event number whose status bit and group-g mask bit are both 1; with nothing pending for that line the whole word reads 0.
- R8: Reads of unmapped or non-word-aligned offsets return 0, and writes to them, or to vector words, change no status or mask bit.
- R9: A single event enabled in several mask groups raises all of the selected lines at once, and each line's vector word reports it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 96 | Event strobes, bit e is event e |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write enable, write happens at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address, combinational |
| irq_o | output | 3 | Interrupt lines, bit g driven through mask group g |

## Verification
The assertions watch, on every cycle, that a strobed event is visible in status one edge later even under a simultaneous clear, that no status bit drops without a one written to it, that masks hold without a write, and that each interrupt line agrees with its vector encoder, whose choice is both pending and the lowest such event. What only the directed scenarios show is the address map itself: that each word lands at its offset, that unmapped and misaligned accesses read zero and touch nothing, and that the vector word encodes the exact event number for chosen routings across banks.

// File: rtl/evt_aggr_pkg.sv
package evt_aggr_pkg;

  // Kind of register selected by a bus address
  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_MASK   = 2'd2,
    SEL_VECTOR = 2'd3
  } sel_kind_e;

  typedef struct packed {
    sel_kind_e  kind;
    logic [3:0] line;
    logic [3:0] word;
  } reg_sel_t;

  // 16-byte pages: page 0 status, pages 1..L masks, page L+1 vectors
  localparam int unsigned PAGE_BYTES = 16;
  localparam int unsigned WORD_BYTES = 4;

  // Bank holding an event
  function automatic int unsigned bank_of(input int unsigned ev, input int unsigned bank_w);
    return ev / bank_w;
  endfunction

  // Bit position of an event inside its bank
  function automatic int unsigned bit_of(input int unsigned ev, input int unsigned bank_w);
    return ev % bank_w;
  endfunction

  // Byte offset of mask word k of group g
  function automatic int unsigned mask_offset(input int unsigned g, input int unsigned k);
    return PAGE_BYTES * (g + 1) + WORD_BYTES * k;
  endfunction

endpackage

// File: rtl/evt_status_bank.sv
module evt_status_bank #(
  parameter int unsigned BANK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] set_i,
  input  logic [BANK_W-1:0] clr_i,
  output logic [BANK_W-1:0] status_o
);

  logic [BANK_W-1:0] status_q;
  logic [BANK_W-1:0] status_d;

  // set has priority over a clear of the same bit
  always_comb status_d = (status_q & ~clr_i) | set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  assign status_o = status_q;

endmodule

// File: rtl/evt_mask_group.sv
module evt_mask_group #(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned BANK_W    = 32,
  localparam int unsigned NUM_EVT  = NUM_BANKS * BANK_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] we_i,
  input  logic [BANK_W-1:0]    wdata_i,
  input  logic [NUM_EVT-1:0]   status_i,
  output logic [NUM_EVT-1:0]   mask_o,
  output logic [NUM_EVT-1:0]   hit_o,
  output logic                 irq_o
);

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_word
    logic [BANK_W-1:0] mask_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '0;
      else if (we_i[k]) mask_q <= wdata_i;
    end
    assign mask_o[k*BANK_W +: BANK_W] = mask_q;
  end

  assign hit_o = status_i & mask_o;
  assign irq_o = |hit_o;

endmodule

// File: rtl/evt_first_encoder.sv
module evt_first_encoder #(
  parameter int unsigned N  = 96,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);

  // scanning downwards leaves the lowest request as the final winner
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end

endmodule

// File: rtl/evt_irq_aggr.sv
module evt_irq_aggr
  import evt_aggr_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned NUM_LINES = 3,
  parameter int unsigned ADDR_W    = 8,
  localparam int unsigned NUM_EVT  = NUM_BANKS * BANK_W,
  localparam int unsigned IDX_W    = $clog2(NUM_EVT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_EVT-1:0]   evt_i,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [BANK_W-1:0]    bus_wdata,
  output logic [BANK_W-1:0]    bus_rdata,
  output logic [NUM_LINES-1:0] irq_o
);

  localparam int unsigned VEC_PAGE = NUM_LINES + 1;

  // Address decode: 16-byte pages of 32-bit words
  function automatic reg_sel_t decode(input logic [ADDR_W-1:0] a);
    reg_sel_t    s;
    int unsigned page;
    int unsigned word;
    s.kind = SEL_NONE;
    s.line = '0;
    s.word = '0;
    page = int'(a) / PAGE_BYTES;
    word = (int'(a) % PAGE_BYTES) / WORD_BYTES;
    if ((int'(a) % WORD_BYTES) == 0) begin
      if (page == 0 && word < NUM_BANKS) begin
        s.kind = SEL_STATUS;
        s.word = 4'(word);
      end else if (page >= 1 && page <= NUM_LINES && word < NUM_BANKS) begin
        s.kind = SEL_MASK;
        s.line = 4'(page - 1);
        s.word = 4'(word);
      end else if (page == VEC_PAGE && word < NUM_LINES) begin
        s.kind = SEL_VECTOR;
        s.line = 4'(word);
      end
    end
    return s;
  endfunction

  reg_sel_t sel;
  assign sel = decode(bus_addr);

  // Named internal events
  logic [NUM_EVT-1:0]                  status_flat;
  logic [NUM_EVT-1:0]                  clr_flat;
  logic [NUM_LINES-1:0][NUM_EVT-1:0]   mask_flat;
  logic [NUM_LINES-1:0][NUM_EVT-1:0]   hit_flat;
  logic [NUM_LINES-1:0]                vec_valid;
  logic [NUM_LINES-1:0][IDX_W-1:0]     vec_idx;

  // Status banks with write-one-to-clear
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_wr;
    assign bank_wr = bus_we && (sel.kind == SEL_STATUS) && (int'(sel.word) == b);
    assign clr_flat[b*BANK_W +: BANK_W] = bank_wr ? bus_wdata : '0;

    evt_status_bank #(.BANK_W(BANK_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (evt_i[b*BANK_W +: BANK_W]),
      .clr_i    (clr_flat[b*BANK_W +: BANK_W]),
      .status_o (status_flat[b*BANK_W +: BANK_W])
    );
  end

  // One mask group and vector encoder per interrupt line
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic [NUM_BANKS-1:0] grp_we;
    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_we
      assign grp_we[k] = bus_we && (sel.kind == SEL_MASK) &&
                         (int'(sel.line) == g) && (int'(sel.word) == k);
    end

    evt_mask_group #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_grp (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (grp_we),
      .wdata_i (bus_wdata),
      .status_i(status_flat),
      .mask_o  (mask_flat[g]),
      .hit_o   (hit_flat[g]),
      .irq_o   (irq_o[g])
    );

    evt_first_encoder #(.N(NUM_EVT)) u_enc (
      .req_i   (hit_flat[g]),
      .valid_o (vec_valid[g]),
      .idx_o   (vec_idx[g])
    );
  end

  // Read mux
  always_comb begin
    bus_rdata = '0;
    unique case (sel.kind)
      SEL_STATUS: bus_rdata = status_flat[int'(sel.word)*BANK_W +: BANK_W];
      SEL_MASK:   bus_rdata = mask_flat[int'(sel.line)][int'(sel.word)*BANK_W +: BANK_W];
      SEL_VECTOR: begin
        bus_rdata[BANK_W-1]  = vec_valid[int'(sel.line)];
        bus_rdata[IDX_W-1:0] = vec_idx[int'(sel.line)];
      end
      default:    bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/evt_irq_aggr_chk.sv
module evt_irq_aggr_chk #(
  parameter int unsigned NUM_EVT   = 96,
  parameter int unsigned NUM_LINES = 3,
  parameter int unsigned IDX_W     = 7
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic [NUM_EVT-1:0]                 evt_i,
  input logic                               bus_we,
  input logic [NUM_EVT-1:0]                 status_flat,
  input logic [NUM_EVT-1:0]                 clr_flat,
  input logic [NUM_LINES-1:0][NUM_EVT-1:0]  mask_flat,
  input logic [NUM_LINES-1:0]               irq_o,
  input logic [NUM_LINES-1:0]               vec_valid,
  input logic [NUM_LINES-1:0][IDX_W-1:0]    vec_idx
);

  // R1: nothing pending and nothing enabled on leaving reset
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (status_flat == '0 && mask_flat == '0));

  // R2, R4: a strobed event shows in status after one edge, clear or not
  a_r2_event_captured: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((status_flat & $past(evt_i)) == $past(evt_i)));

  // R3: a status bit only drops where a one was written to it
  a_r3_no_spontaneous_clear: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(status_flat) & ~status_flat) & ~$past(clr_flat)) == '0));

  // R5: masks hold without a bus write
  a_r5_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(mask_flat));

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_chk
    // R6: interrupt line and vector encoder agree
    a_r6_irq_vector_agree: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[g] == vec_valid[g]);

    // R7: reported event is pending and enabled
    a_r7_vector_pending: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid[g] |-> (status_flat[vec_idx[g]] && mask_flat[g][vec_idx[g]]));

    // R7: no enabled pending event below the reported one
    a_r7_vector_lowest: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid[g] |->
        (((status_flat & mask_flat[g]) & ~({NUM_EVT{1'b1}} << vec_idx[g])) == '0));
  end

endmodule

bind evt_irq_aggr evt_irq_aggr_chk #(
  .NUM_EVT   (NUM_EVT),
  .NUM_LINES (NUM_LINES),
  .IDX_W     (IDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .evt_i       (evt_i),
  .bus_we      (bus_we),
  .status_flat (status_flat),
  .clr_flat    (clr_flat),
  .mask_flat   (mask_flat),
  .irq_o       (irq_o),
  .vec_valid   (vec_valid),
  .vec_idx     (vec_idx)
);

// File: tb/tb_evt_irq_aggr.sv
module tb_evt_irq_aggr;

  localparam int NEV = 96;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NEV-1:0] evt_i = '0;
  logic [7:0]    bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [2:0]    irq_o;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  evt_irq_aggr dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // Offsets restated from the requirements
  function automatic logic [7:0] stat_off(input int n);  return 8'(4 * n); endfunction
  function automatic logic [7:0] mask_off(input int g, input int k); return 8'(16 * (g + 1) + 4 * k); endfunction
  function automatic logic [7:0] vec_off(input int g);   return 8'(8'h40 + 4 * g); endfunction
  function automatic logic [31:0] vec_word(input int e); return 32'h8000_0000 | 32'(e); endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic read_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    reg_read(a, d);
    check(req, $sformatf("read 0x%02h", a), d, exp);
  endtask

  task automatic pulse_event(input int e);
    @(negedge clk);
    evt_i = '0; evt_i[e] = 1'b1;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic irq_check(input string req, input logic [2:0] exp);
    @(negedge clk);
    #1 check(req, "irq lines", 32'(irq_o), 32'(exp));
  endtask

  task automatic t_reset;
    for (int n = 0; n < 3; n++) read_check("R1", stat_off(n), 32'h0);
    for (int g = 0; g < 3; g++) read_check("R1", mask_off(g, 2), 32'h0);
    for (int g = 0; g < 3; g++) read_check("R1", vec_off(g), 32'h0);
    irq_check("R1", 3'b000);
  endtask

  task automatic t_capture;
    pulse_event(0); pulse_event(37); pulse_event(95);
    read_check("R2", stat_off(0), 32'h0000_0001);
    read_check("R2", stat_off(1), 32'h0000_0020);
    read_check("R2", stat_off(2), 32'h8000_0000);
    irq_check("R6", 3'b000);
  endtask

  task automatic t_mask;
    reg_write(mask_off(1, 2), 32'h8000_0000);
    read_check("R5", mask_off(1, 2), 32'h8000_0000);
    read_check("R5", mask_off(1, 1), 32'h0);
    irq_check("R6", 3'b010);
    read_check("R7", vec_off(1), vec_word(95));
    read_check("R7", vec_off(0), 32'h0);
    read_check("R7", vec_off(2), 32'h0);
  endtask

  task automatic t_w1c;
    reg_write(stat_off(2), 32'h0);
    read_check("R3", stat_off(2), 32'h8000_0000);
    irq_check("R6", 3'b010);
    reg_write(stat_off(0), 32'h0000_0002);
    read_check("R3", stat_off(0), 32'h0000_0001);
    reg_write(stat_off(2), 32'h8000_0000);
    read_check("R3", stat_off(2), 32'h0);
    irq_check("R6", 3'b000);
    read_check("R7", vec_off(1), 32'h0);
  endtask

  task automatic t_set_wins;
    @(negedge clk);
    evt_i = '0; evt_i[40] = 1'b1;
    bus_addr = stat_off(1); bus_wdata = 32'h0000_0100; bus_we = 1'b1;
    @(negedge clk);
    evt_i = '0; bus_we = 1'b0;
    read_check("R4", stat_off(1), 32'h0000_0120);
    reg_write(stat_off(1), 32'h0000_0100);
    read_check("R3", stat_off(1), 32'h0000_0020);
  endtask

  task automatic t_routing;
    pulse_event(70);
    reg_write(mask_off(0, 2), 32'h0000_0040);
    reg_write(mask_off(2, 2), 32'h0000_0040);
    irq_check("R9", 3'b101);
    read_check("R9", vec_off(0), vec_word(70));
    read_check("R9", vec_off(2), vec_word(70));
    reg_write(mask_off(2, 1), 32'h0000_0020);
    read_check("R7", vec_off(2), vec_word(37));
    repeat (5) @(negedge clk);
    irq_check("R6", 3'b101);
    reg_write(mask_off(0, 2), 32'h0);
    irq_check("R6", 3'b100);
    reg_write(mask_off(1, 0), 32'h0000_0001);
    irq_check("R9", 3'b110);
    read_check("R7", vec_off(1), vec_word(0));
  endtask

  task automatic t_unmapped;
    read_check("R8", 8'h0C, 32'h0);
    read_check("R8", 8'h1C, 32'h0);
    read_check("R8", 8'h4C, 32'h0);
    read_check("R8", 8'h50, 32'h0);
    read_check("R8", 8'h01, 32'h0);
    read_check("R8", 8'h21, 32'h0);
    reg_write(8'h0C, 32'hFFFF_FFFF);
    reg_write(8'h3C, 32'hFFFF_FFFF);
    reg_write(8'h50, 32'hFFFF_FFFF);
    reg_write(8'h11, 32'hFFFF_FFFF);
    reg_write(8'h05, 32'hFFFF_FFFF);
    reg_write(vec_off(0), 32'hFFFF_FFFF);
    read_check("R8", mask_off(0, 0), 32'h0);
    read_check("R8", mask_off(0, 1), 32'h0);
    read_check("R8", stat_off(1), 32'h0000_0020);
    read_check("R8", vec_off(0), 32'h0);
    irq_check("R8", 3'b110);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_capture();
    t_mask();
    t_w1c();
    t_set_wins();
    t_routing();
    t_unmapped();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule